// File: doc/BRIEF.md
# Balanced-Ternary Gate Encoder for a Three-Bridge Cascaded Inverter

This block drives the twelve switches of three H-bridges connected in series, each fed from its own DC source, with the sources sized 1, 3 and 9 units. Each bridge contributes -1, 0 or +1 times its own source, and the output voltage is the sum of the three. A single signed level request from -13 to +13 therefore selects any of 27 output steps.

Each cycle the encoder registers the request and clamps it to the legal span. It splits the level into three balanced-ternary digits, one per bridge, and turns each digit into a four-switch pattern. When a bridge must change pattern, all four of that bridge's gates are first held off for a programmable number of cycles. A sticky flag records any request that fell outside the legal span. Carrier comparison, which produces the level request, sits upstream of this block.

Top module: `tern_bridge_enc`

## Requirements
- R1: While reset is active and right after it ends, every bridge holds the zero digit. `gate_o` reads 12'h555, `digit_o` reads 0 and `range_err_o` reads 0.
- R2: In steady state, `digit_o` holds three 2-bit digit codes: 2'b01 for +1, 2'b00 for 0 and 2'b11 for -1. Bits [1:0] belong to the weight-1 bridge, [3:2] to the weight-3 bridge and [5:4] to the weight-9 bridge. The digits satisfy L = 9*d9 + 3*d3 + d1, where L is the clamped level. Code 2'b10 never appears.
- R3: Bits [3:0], [7:4] and [11:8] of `gate_o` drive the weight-1, weight-3 and weight-9 bridges, and bit 0 of each nibble is that bridge's first switch. Digit +1 gives nibble 4'b1001, digit -1 gives 4'b0110 and digit 0 gives 4'b0101.
- R4: With `dead_i` at 0, a new level sampled at one rising edge appears on `gate_o` and `digit_o` after the following rising edge, with no gap.
- R5: With `dead_i` = N > 0, a bridge whose digit changes shows nibble 4'b0000 for exactly N cycles before its new pattern appears. A bridge whose digit does not change keeps its pattern throughout.
- R6: A request above +13 acts as +13, and a request below -13 acts as -13.
- R7: `range_err_o` goes high one cycle after an out-of-span request is sampled. It then stays high until reset.
- R8: The two switches of a leg (nibble bits 0 and 1, or bits 2 and 3) are never on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| level_i | input | 5 | Signed level request, two's complement |
| dead_i | input | DEAD_W | Gate-off cycles inserted before a bridge changes pattern |
| gate_o | output | 12 | Switch gates, three nibbles ordered by bridge weight 1, 3, 9 |
| digit_o | output | 6 | Applied digit per bridge, 2-bit code per bridge |
| range_err_o | output | 1 | Sticky out-of-span flag |

## Verification
The hardest case to reach from the ports is a bridge whose digit changes while its neighbours keep theirs, combined with a nonzero dead time. Only in that case can a gap that is one cycle off, or a neighbour wrongly blanked, be told apart. Directed steps from 0 to +1 change only the weight-1 bridge, and the bench counts the blanked cycles on that nibble one cycle at a time. Random levels and dead times across the full 5-bit input span, clamped codes included, then exercise every digit transition.

// File: rtl/tern_bridge_enc.sv
module tern_bridge_enc #(
  parameter int DEAD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic signed [4:0] level_i,
  input  logic [DEAD_W-1:0] dead_i,
  output logic [11:0]       gate_o,
  output logic [5:0]        digit_o,
  output logic              range_err_o
);

  localparam int NB = 3;

  function automatic logic [3:0] trit_pat(input logic [1:0] t);
    case (t)
      2'd0:    trit_pat = 4'b0110;
      2'd2:    trit_pat = 4'b1001;
      default: trit_pat = 4'b0101;
    endcase
  endfunction

  function automatic logic [1:0] trit_code(input logic [1:0] t);
    case (t)
      2'd0:    trit_code = 2'b11;
      2'd2:    trit_code = 2'b01;
      default: trit_code = 2'b00;
    endcase
  endfunction

  logic signed [4:0] lvl_q;
  logic              too_hi, too_lo;
  logic [4:0]        ofs, ofs_div;

  assign too_hi = level_i > 5'sd13;
  assign too_lo = level_i < -5'sd13;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q       <= '0;
      range_err_o <= 1'b0;
    end else begin
      lvl_q       <= too_hi ? 5'sd13 : (too_lo ? -5'sd13 : level_i);
      range_err_o <= range_err_o | too_hi | too_lo;
    end
  end

  assign ofs     = 5'(lvl_q + 5'sd13);
  assign ofs_div = ofs / 5'd3;

  logic [1:0] tgt [NB];
  assign tgt[0] = 2'(ofs % 5'd3);
  assign tgt[1] = 2'(ofs_div % 5'd3);
  assign tgt[2] = 2'(ofs_div / 5'd3);

  for (genvar b = 0; b < NB; b++) begin : g_br
    logic [1:0]        app;
    logic              busy;
    logic [DEAD_W-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        app  <= 2'd1;
        busy <= 1'b0;
        cnt  <= '0;
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          app  <= tgt[b];
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (tgt[b] != app) begin
        if (dead_i == '0) begin
          app <= tgt[b];
        end else begin
          busy <= 1'b1;
          cnt  <= dead_i - 1'b1;
        end
      end
    end

    assign gate_o[4*b +: 4]  = busy ? 4'b0000 : trit_pat(app);
    assign digit_o[2*b +: 2] = trit_code(app);
  end

endmodule

module tern_bridge_enc_chk #(
  parameter int DEAD_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic signed [4:0] level_i,
  input logic [DEAD_W-1:0] dead_i,
  input logic [11:0]       gate_o,
  input logic [5:0]        digit_o,
  input logic              range_err_o
);

  assert_no_shoot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o & (gate_o >> 1) & 12'h555) == 12'h000);

  assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    digit_o[1:0] != 2'b10 && digit_o[3:2] != 2'b10 && digit_o[5:4] != 2'b10);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    range_err_o |=> range_err_o);

  assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (level_i > 5'sd13 || level_i < -5'sd13) |=> range_err_o);

  for (genvar b = 0; b < 3; b++) begin : g_chk
    assert_dead_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_o[4*b +: 4] != 4'b0 && $past(gate_o[4*b +: 4]) != 4'b0 &&
       gate_o[4*b +: 4] != $past(gate_o[4*b +: 4])) |-> $past(dead_i) == '0);
  end

endmodule

bind tern_bridge_enc tern_bridge_enc_chk #(.DEAD_W(DEAD_W)) chk_i (.*);

// File: tb/tern_bridge_enc_tb.sv
module tern_bridge_enc_tb_top;
  localparam int DEAD_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic signed [4:0] level_i = '0;
  logic [DEAD_W-1:0] dead_i = '0;
  logic [11:0]       gate_o;
  logic [5:0]        digit_o;
  logic              range_err_o;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  tern_bridge_enc #(.DEAD_W(DEAD_W)) dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int clampv(input int l);
    return l > 13 ? 13 : (l < -13 ? -13 : l);
  endfunction

  function automatic logic [3:0] nib_of(input int d);
    return d > 0 ? 4'b1001 : (d < 0 ? 4'b0110 : 4'b0101);
  endfunction

  function automatic logic [1:0] code_of(input int d);
    return d > 0 ? 2'b01 : (d < 0 ? 2'b11 : 2'b00);
  endfunction

  function automatic logic [17:0] expect_of(input int l);
    int c = clampv(l);
    logic [17:0] r = '0;
    for (int a = -1; a <= 1; a++)
      for (int m = -1; m <= 1; m++)
        for (int u = -1; u <= 1; u++)
          if (9*a + 3*m + u == c)
            r = {code_of(a), code_of(m), code_of(u), nib_of(a), nib_of(m), nib_of(u)};
    return r;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_steady(input int l, input string tag);
    logic [17:0] e = expect_of(l);
    check(gate_o == e[11:0], {tag, " gates"}, int'(gate_o), int'(e[11:0]));
    check(digit_o == e[17:12], {tag, " digits"}, int'(digit_o), int'(e[17:12]));
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit exp_err;
    int zeros;
    bit others_ok;
    void'($urandom(32'd7));
    cyc(4);
    check(gate_o == 12'h555, "R1 reset gates", int'(gate_o), 'h555);
    rst_n = 1'b1;
    cyc(1);
    check(gate_o == 12'h555, "R1 gates", int'(gate_o), 'h555);
    check(digit_o == 6'd0, "R1 digits", int'(digit_o), 0);
    check(range_err_o == 1'b0, "R1 err", int'(range_err_o), 0);

    // R4 latency with zero dead time
    dead_i = 0; level_i = 5'sd13;
    cyc(1);
    check(gate_o == 12'h555, "R4 still old", int'(gate_o), 'h555);
    cyc(1);
    check(gate_o == 12'h999, "R4 new after 2 edges", int'(gate_o), 'h999);
    check(digit_o == 6'b010101, "R2 digits +13", int'(digit_o), 'b010101);

    // R3 mixed digits: 5 = 9 - 3 - 1
    level_i = 5'sd5; cyc(3);
    check(gate_o == 12'h966, "R3 level 5 gates", int'(gate_o), 'h966);
    check(digit_o == 6'b011111, "R2 level 5 digits", int'(digit_o), 'b011111);

    // R5 dead time on a single bridge
    level_i = 5'sd0; cyc(3);
    dead_i = 3; level_i = 5'sd1;
    cyc(1);
    check(gate_o == 12'h555, "R5 before detect", int'(gate_o), 'h555);
    zeros = 0; others_ok = 1'b1;
    for (int k = 0; k < 6; k++) begin
      cyc(1);
      if (gate_o[3:0] == 4'b0000) zeros++;
      if (gate_o[11:4] != 8'h55) others_ok = 1'b0;
    end
    check(zeros == 3, "R5 gap length", zeros, 3);
    check(others_ok, "R5 neighbours untouched", int'(others_ok), 1);
    check(gate_o == 12'h559, "R5 final pattern", int'(gate_o), 'h559);

    // R5 several bridges, then steady
    dead_i = 2; level_i = -5'sd4; cyc(6);
    check_steady(-4, "R5 level -4");

    // R6 / R7 clamping and sticky error
    check(range_err_o == 1'b0, "R7 err clear before", int'(range_err_o), 0);
    dead_i = 0; level_i = 5'sd15; cyc(3);
    check_steady(13, "R6 clamp high");
    check(range_err_o == 1'b1, "R7 err set", int'(range_err_o), 1);
    level_i = -5'sd16; cyc(3);
    check_steady(-13, "R6 clamp low");
    level_i = 5'sd2; cyc(3);
    check(range_err_o == 1'b1, "R7 err sticky", int'(range_err_o), 1);

    // random
    exp_err = 1'b1;
    for (int i = 0; i < 300; i++) begin
      int lv;
      bit leg_ok;
      dead_i = DEAD_W'($urandom_range(3));
      level_i = 5'($urandom_range(31));
      lv = int'(level_i);
      leg_ok = 1'b1;
      for (int k = 0; k < 8; k++) begin
        cyc(1);
        if ((gate_o & (gate_o >> 1) & 12'h555) != 0) leg_ok = 1'b0;
      end
      check(leg_ok, "R8 legs", int'(gate_o), 0);
      check_steady(lv, "R2 R3 R6 random");
      check(range_err_o == exp_err, "R7 random", int'(range_err_o), int'(exp_err));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule